// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries data words from one clock domain to another, unrelated one. A producer in the write domain pushes a word on each write-clock edge where its enable is high and the full flag is low. A consumer in the read domain sees the oldest stored word on the read data port whenever the empty flag is low. It pops that word by holding its enable high across a read-clock edge.

Each side keeps a binary counter with one more bit than the storage address needs. It also keeps a registered Gray-coded copy of the next count. Only the Gray copy leaves its domain, through a two-register synchronizer clocked by the receiving side, so at most one bit can change per crossing. Full is decided in the write domain and empty in the read domain. Each flag is registered from the side's own next pointer and compared against the synchronized pointer from the other side.

A flag may stay asserted for a few cycles after the far side has moved. That delay costs a few cycles of throughput but can never overrun or underrun the storage. The storage depth is a power-of-two parameter.

Top module: `xdom_fifo`

## Requirements
- R1: After reset, `rd_empty` is 1 and `wr_full` is 0.
- R2: Words leave the read port in the order they were accepted on the write side, with none lost or repeated. This holds under independent random enables on both sides and across many pointer wraps.
- R3: While `wr_full` is 1, a write request is ignored: the word is not stored and no stored word is overwritten.
- R4: While `rd_empty` is 1, a read request is ignored and the read position does not move.
- R5: With no reads, `wr_full` is 0 after DEPTH-1 accepted writes. It reads 1 right after the write-clock edge that accepts the DEPTH-th word.
- R6: After a write into an empty FIFO, `rd_empty` falls within 4 read-clock rising edges and never in the same domain cycle as the write.
- R7: After a read from a full FIFO, `wr_full` falls within 4 write-clock rising edges. `rd_empty` rises right after the read-clock edge that pops the last stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain synchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Storage full, writes ignored |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain synchronous reset, active low |
| rd_en | input | 1 | Read request, pops the word on rd_data |
| rd_data | output | DATA_W | Oldest stored word |
| rd_empty | output | 1 | Storage empty, reads ignored |

## Verification
A corrupted pointer or a wrong wrap bit shows up at the data port at the next pop: a word comes out of order, twice, or not at all. The reference queue catches this on the first affected read. A bad full or empty compare is visible as soon as the flag should change. Full is missing on the edge after the DEPTH-th write, an extra write gets through while the queue already holds DEPTH words, or empty is late to rise after the last pop. A broken synchronizer path leaves a flag stuck past the four-edge release window.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;
    typedef enum logic {
        SIDE_WRITE = 1'b0,
        SIDE_READ  = 1'b1
    } side_e;
endpackage

// File: rtl/xdom_fifo_sync.sv
module xdom_fifo_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = d;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.stable;

    // R6: output stage copies the first stage one cycle later, nothing in between
    assert_sync_pipe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(s_q.meta)));
endmodule

// File: rtl/xdom_fifo_ptr.sv
module xdom_fifo_ptr
    import xdom_fifo_pkg::*;
#(
    parameter int unsigned AW   = 3,
    parameter side_e       SIDE = SIDE_WRITE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [AW:0]   peer_gray,
    output logic [AW-1:0] addr,
    output logic [AW:0]   gray,
    output logic          flag
);
    localparam logic FLAG_RST = (SIDE == SIDE_READ);
    localparam logic [AW:0] TOP2 = {2'b11, {(AW-1){1'b0}}};

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        flag;
    } ptr_t;

    ptr_t        p_d, p_q;
    logic        step;
    logic [AW:0] bin_nx;
    logic [AW:0] gray_nx;
    logic        hit;

    assign step    = req && !p_q.flag;
    assign bin_nx  = p_q.bin + {{AW{1'b0}}, step};
    assign gray_nx = bin_nx ^ (bin_nx >> 1);

    generate
        if (SIDE == SIDE_WRITE) begin : g_full
            assign hit = (gray_nx == (peer_gray ^ TOP2));
        end else begin : g_empty
            assign hit = (gray_nx == peer_gray);
        end
    endgenerate

    always_comb begin
        p_d      = p_q;
        p_d.bin  = bin_nx;
        p_d.gray = gray_nx;
        p_d.flag = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '{bin: '0, gray: '0, flag: FLAG_RST};
        else        p_q <= p_d;
    end

    assign addr = p_q.bin[AW-1:0];
    assign gray = p_q.gray;
    assign flag = p_q.flag;

    // R2: the crossing pointer moves by at most one bit per cycle
    assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(p_q.gray ^ $past(p_q.gray)) <= 1);

    generate
        if (SIDE == SIDE_WRITE) begin : g_wchk
            assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
                p_q.flag |=> $stable(p_q.bin));
            assert_reset_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> !p_q.flag);
        end else begin : g_rchk
            assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
                p_q.flag |=> $stable(p_q.bin));
            assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> p_q.flag);
        end
    endgenerate
endmodule

// File: rtl/xdom_fifo_mem.sv
module xdom_fifo_mem #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned ENTRIES = 1 << AW;

    logic [DW-1:0] cell_q [ENTRIES];

    always_ff @(posedge wclk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo
    import xdom_fifo_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_in_rd, rgray_in_wr;

    xdom_fifo_ptr #(.AW(AW), .SIDE(SIDE_WRITE)) u_wptr (
        .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_en), .peer_gray(rgray_in_wr),
        .addr(waddr), .gray(wgray), .flag(wr_full)
    );

    xdom_fifo_ptr #(.AW(AW), .SIDE(SIDE_READ)) u_rptr (
        .clk(rd_clk), .rst_n(rd_rst_n), .req(rd_en), .peer_gray(wgray_in_rd),
        .addr(raddr), .gray(rgray), .flag(rd_empty)
    );

    xdom_fifo_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_in_rd)
    );

    xdom_fifo_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_in_wr)
    );

    xdom_fifo_mem #(.DW(DATA_W), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(wr_en && !wr_full), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: tb/xdom_fifo_bench.sv
`timescale 1ns/1ps
module xdom_fifo_bench;
    localparam int DW = 8;
    localparam int DEPTH = 8;

    logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic wr_full, rd_empty;

    int total = 0, bad = 0;
    bit done = 0;
    logic [DW-1:0] ref_q[$];

    always #5 wr_clk = ~wr_clk;
    always #6.85 rd_clk = ~rd_clk;

    xdom_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_xdom_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // one write-side cycle; input driven at falling edge
    task automatic wr_cycle(input bit en, input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = en; wr_data = d;
        if (en && !wr_full) begin
            check(ref_q.size() < DEPTH, "R3 write accepted past full", ref_q.size(), DEPTH - 1);
            ref_q.push_back(d);
        end
    endtask

    // one read-side cycle; returns 1 when a pop was checked
    task automatic rd_cycle(input bit en, output bit popped);
        @(negedge rd_clk);
        rd_en = en; popped = 0;
        if (en && !rd_empty) begin
            popped = 1;
            if (ref_q.size() == 0) check(0, "R4 read past empty", 1, 0);
            else begin
                logic [DW-1:0] e;
                e = ref_q.pop_front();
                check(rd_data == e, "R2 data order", rd_data, e);
            end
        end
    endtask

    task automatic drain(input int n);
        int got = 0;
        for (int t = 0; t < 200 && got < n; t++) begin
            bit p;
            rd_cycle(1, p);
            if (p) got++;
        end
        @(negedge rd_clk); rd_en = 0;
        check(got == n, "R2 drain count", got, n);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge wr_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        @(negedge rd_clk); @(negedge wr_clk);
        check(rd_empty == 1, "R1 empty after reset", rd_empty, 1);
        check(wr_full == 0, "R1 full after reset", wr_full, 0);
    endtask

    task automatic t_fill_block();
        for (int i = 0; i < DEPTH; i++) begin
            if (i == DEPTH - 1) check(wr_full == 0, "R5 not full at DEPTH-1", wr_full, 0);
            wr_cycle(1, DW'(8'hA0 + i));
        end
        @(negedge wr_clk);
        check(wr_full == 1, "R5 full after DEPTH writes", wr_full, 1);
        wr_data = 8'hEE;   // R3: request held while full, must be dropped
        @(negedge wr_clk);
        check(wr_full == 1, "R3 still full", wr_full, 1);
        wr_en = 0;
        repeat (6) @(negedge rd_clk);
        drain(DEPTH);
        check(rd_empty == 1, "R7 empty right after last pop", rd_empty, 1);
        check(ref_q.size() == 0, "R3 extra word absent", ref_q.size(), 0);
    endtask

    task automatic t_empty_block();
        bit p;
        for (int i = 0; i < 3; i++) begin
            rd_cycle(1, p);
            check(p == 0, "R4 read while empty ignored", p, 0);
        end
        @(negedge rd_clk); rd_en = 0;
        check(rd_empty == 1, "R4 still empty", rd_empty, 1);
        wr_cycle(1, 8'h5A);
        @(negedge wr_clk); wr_en = 0;
        begin
            int n = 0;
            while (rd_empty && n < 10) begin @(posedge rd_clk); #1; n++; end
            check(n >= 1 && n <= 4, "R6 empty release latency", n, 3);
        end
        drain(1);   // R4: word must be 5A, proving the pointer did not move
    endtask

    task automatic t_full_release();
        for (int i = 0; i < DEPTH; i++) wr_cycle(1, DW'(8'h30 + i));
        @(negedge wr_clk); wr_en = 0;
        check(wr_full == 1, "R5 full again", wr_full, 1);
        repeat (6) @(negedge rd_clk);
        drain(1);
        begin
            int n = 0;
            while (wr_full && n < 10) begin @(posedge wr_clk); #1; n++; end
            check(n >= 1 && n <= 4, "R7 full release latency", n, 3);
        end
        drain(DEPTH - 1);
    endtask

    task automatic t_random();
        localparam int N = 300;
        int sent = 0, got = 0;
        fork
            begin
                for (int t = 0; t < 4000 && sent < N; t++) begin
                    bit en;
                    en = ($urandom % 10) < 6;
                    @(negedge wr_clk);
                    wr_en = en; wr_data = DW'($urandom);
                    if (en && !wr_full) begin
                        if (ref_q.size() >= DEPTH) check(0, "R3 random overflow", ref_q.size(), DEPTH - 1);
                        ref_q.push_back(wr_data);
                        sent++;
                    end
                end
                @(negedge wr_clk); wr_en = 0;
            end
            begin
                for (int t = 0; t < 6000 && got < N; t++) begin
                    bit p;
                    rd_cycle(($urandom % 2) == 1, p);
                    if (p) got++;
                end
                @(negedge rd_clk); rd_en = 0;
            end
        join
        check(got == N, "R2 random words delivered across wraps", got, N);
        check(ref_q.size() == 0, "R2 nothing left over", ref_q.size(), 0);
    endtask

    initial begin
        #2_000_000;
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        t_reset();
        t_fill_block();
        t_empty_block();
        t_full_release();
        t_random();
        finish_run();
    end
endmodule